// File: doc/BRIEF.md
# Vector Compare Instruction Decoder

This block takes one 32-bit instruction word and decides, in pure combinational logic, whether it is a vector compare. Two encodings are recognised. The standard form uses a 5-bit register space and a 10-bit extended opcode. The wide form uses a 7-bit register space, with the compare kind and the record flag packed into a few sub-opcode bits. For a recognised compare the block reports a valid flag, an operation code, the encoding that matched, the record (Rc) flag and the three register numbers. For any other word it reports a quiet, all-zero result.

The record flag is the subtle part. In neither form does it sit in the least significant bit. All standard compare extended opcodes are even, so a decoder reading that bit would never request a condition update. In the wide space, a word with the record flag set may also belong to a neighbouring shift/merge group. One extra bit tells the two apart, and the decoder must test it.

Bit indices below are LSB-based: bit 0 is the least significant bit of `insn_i`. The primary opcode is `insn_i[31:26]`.

Top module: `vcmp_decode`

## Requirements
- R1: With primary opcode 4, the standard form is decoded from the extended opcode in `insn_i[9:0]`. The values map to operation codes as follows: 6→1 (equal u8), 70→2 (equal u16), 134→3 (equal u32), 198→4 (equal f32), 454→5 (greater-or-equal f32), 710→6 (greater f32), 966→7 (bounds f32), 518→8 (greater u8), 582→9 (greater u16), 646→10 (greater u32), 774→11 (greater s8), 838→12 (greater s16), 902→13 (greater s32). A match gives `valid_o`=1 and `form_o`=0. Every other extended opcode is invalid.
- R2: For a valid standard-form compare, `rc_o` equals `insn_i[10]`. `insn_i[0]` never drives `rc_o`.
- R3: For a valid standard-form compare, `vd_o`=`insn_i[25:21]`, `va_o`=`insn_i[20:16]` and `vb_o`=`insn_i[15:11]`, each zero-extended to 7 bits.
- R4: With primary opcode 6 and `insn_i[4]`=0, the word is a wide non-recording compare selected by `insn_i[9:7]`: 000→4, 001→5, 010→6, 100→3. `insn_i[6]` is ignored. The selectors 011, 101, 110 and 111 are invalid. A match gives `form_o`=1 and `rc_o`=0.
- R5: With primary opcode 6, `insn_i[4]`=1 and `insn_i[6]`=0, the word is a wide recording compare selected by `insn_i[9:7]`: 000→4, 001→5, 010→6, 011→7, 100→3. Any other selector is invalid. A match gives `form_o`=1 and `rc_o`=1.
- R6: With primary opcode 6, `insn_i[4]`=1 and `insn_i[6]`=1, the word belongs to the shift/merge group and is never reported as a compare.
- R7: Any word not matched by R1, R4 or R5, including every primary opcode other than 4 and 6, drives `valid_o`, `op_o` (code 0), `form_o`, `rc_o` and all three register outputs to 0.
- R8: For a valid wide-form compare, `vd_o`={`insn_i[3:2]`,`insn_i[25:21]`}, `va_o`={`insn_i[5]`,`insn_i[10]`,`insn_i[20:16]`} and `vb_o`={`insn_i[1:0]`,`insn_i[15:11]`}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn_i | input | 32 | Instruction word to decode |
| valid_o | output | 1 | Word is a recognised vector compare |
| op_o | output | 4 | Operation code (0 = none) |
| form_o | output | 1 | 0 = standard form, 1 = wide form |
| rc_o | output | 1 | Record flag: compare must update the condition field |
| vd_o | output | 7 | Destination register number |
| va_o | output | 7 | First source register number |
| vb_o | output | 7 | Second source register number |

## Verification
Every output is a combinational function of `insn_i`, so each result is due in the same cycle as its word, with no register on the path. The bench applies each word just after a falling clock edge and samples all outputs 2 ns later, well before the next rising edge. The sweep covers all 64 values of `insn_i[9:4]` in the wide space and all 2048 combinations of the standard extended opcode and the record bit, each against several fill patterns in the remaining bits. It then steps through every other primary opcode.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;

  localparam int INSN_W = 32;
  localparam int REG_W  = 7;
  localparam int OP_W   = 4;
  localparam int NARROW_W = 5;
  localparam int XO_W   = 10;

  localparam logic [5:0] PRI_STD  = 6'd4;
  localparam logic [5:0] PRI_WIDE = 6'd6;

  typedef enum logic [OP_W-1:0] {
    VOP_NONE    = 4'd0,
    VOP_EQ_U8   = 4'd1,
    VOP_EQ_U16  = 4'd2,
    VOP_EQ_U32  = 4'd3,
    VOP_EQ_F32  = 4'd4,
    VOP_GE_F32  = 4'd5,
    VOP_GT_F32  = 4'd6,
    VOP_BND_F32 = 4'd7,
    VOP_GT_U8   = 4'd8,
    VOP_GT_U16  = 4'd9,
    VOP_GT_U32  = 4'd10,
    VOP_GT_S8   = 4'd11,
    VOP_GT_S16  = 4'd12,
    VOP_GT_S32  = 4'd13
  } vop_e;

  localparam logic FORM_STD  = 1'b0;
  localparam logic FORM_WIDE = 1'b1;

  typedef struct packed {
    logic             hit;
    vop_e             op;
    logic             rc;
    logic [REG_W-1:0] rd;
    logic [REG_W-1:0] ra;
    logic [REG_W-1:0] rb;
  } vdec_t;

endpackage

// File: rtl/vcmp_std_dec.sv
module vcmp_std_dec
  import vcmp_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  output vdec_t             res_o
);

  localparam int PAD_W = REG_W - NARROW_W;

  logic [XO_W-1:0] xo;
  vop_e            op_sel;

  assign xo = insn_i[XO_W-1:0];

  // Extended opcode lookup; all entries are even values.
  always_comb begin
    op_sel = VOP_NONE;
    unique case (xo)
      10'd6:   op_sel = VOP_EQ_U8;
      10'd70:  op_sel = VOP_EQ_U16;
      10'd134: op_sel = VOP_EQ_U32;
      10'd198: op_sel = VOP_EQ_F32;
      10'd454: op_sel = VOP_GE_F32;
      10'd710: op_sel = VOP_GT_F32;
      10'd966: op_sel = VOP_BND_F32;
      10'd518: op_sel = VOP_GT_U8;
      10'd582: op_sel = VOP_GT_U16;
      10'd646: op_sel = VOP_GT_U32;
      10'd774: op_sel = VOP_GT_S8;
      10'd838: op_sel = VOP_GT_S16;
      10'd902: op_sel = VOP_GT_S32;
      default: op_sel = VOP_NONE;
    endcase
  end

  always_comb begin
    res_o = '0;
    if (insn_i[31:26] == PRI_STD && op_sel != VOP_NONE) begin
      res_o.hit = 1'b1;
      res_o.op  = op_sel;
      res_o.rc  = insn_i[10];
      res_o.rd  = {{PAD_W{1'b0}}, insn_i[25:21]};
      res_o.ra  = {{PAD_W{1'b0}}, insn_i[20:16]};
      res_o.rb  = {{PAD_W{1'b0}}, insn_i[15:11]};
    end
  end

endmodule

// File: rtl/vcmp_wide_dec.sv
module vcmp_wide_dec
  import vcmp_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  output vdec_t             res_o
);

  logic [2:0] sel;
  logic       rec;
  logic       grp;
  vop_e       op_plain;
  vop_e       op_rec;
  vop_e       op_sel;

  assign sel = insn_i[9:7];
  assign rec = insn_i[4];
  assign grp = insn_i[6];

  always_comb begin
    op_plain = VOP_NONE;
    unique case (sel)
      3'b000:  op_plain = VOP_EQ_F32;
      3'b001:  op_plain = VOP_GE_F32;
      3'b010:  op_plain = VOP_GT_F32;
      3'b100:  op_plain = VOP_EQ_U32;
      default: op_plain = VOP_NONE;
    endcase
  end

  always_comb begin
    op_rec = VOP_NONE;
    unique case (sel)
      3'b000:  op_rec = VOP_EQ_F32;
      3'b001:  op_rec = VOP_GE_F32;
      3'b010:  op_rec = VOP_GT_F32;
      3'b011:  op_rec = VOP_BND_F32;
      3'b100:  op_rec = VOP_EQ_U32;
      default: op_rec = VOP_NONE;
    endcase
  end

  // Recording words qualify only when the group bit is clear;
  // otherwise they belong to the shift/merge neighbours.
  always_comb begin
    if (!rec)      op_sel = op_plain;
    else if (!grp) op_sel = op_rec;
    else           op_sel = VOP_NONE;
  end

  always_comb begin
    res_o = '0;
    if (insn_i[31:26] == PRI_WIDE && op_sel != VOP_NONE) begin
      res_o.hit = 1'b1;
      res_o.op  = op_sel;
      res_o.rc  = rec;
      res_o.rd  = {insn_i[3:2], insn_i[25:21]};
      res_o.ra  = {insn_i[5], insn_i[10], insn_i[20:16]};
      res_o.rb  = {insn_i[1:0], insn_i[15:11]};
    end
  end

endmodule

// File: rtl/vcmp_decode.sv
module vcmp_decode
  import vcmp_pkg::*;
(
  input  logic [31:0] insn_i,
  output logic        valid_o,
  output logic [3:0]  op_o,
  output logic        form_o,
  output logic        rc_o,
  output logic [6:0]  vd_o,
  output logic [6:0]  va_o,
  output logic [6:0]  vb_o
);

  vdec_t std_res;
  vdec_t wide_res;
  vdec_t pick;
  logic  pick_form;

  vcmp_std_dec u_std (
    .insn_i (insn_i),
    .res_o  (std_res)
  );

  vcmp_wide_dec u_wide (
    .insn_i (insn_i),
    .res_o  (wide_res)
  );

  always_comb begin
    pick      = '0;
    pick_form = FORM_STD;
    if (std_res.hit) begin
      pick = std_res;
    end else if (wide_res.hit) begin
      pick      = wide_res;
      pick_form = FORM_WIDE;
    end
  end

  assign valid_o = pick.hit;
  assign op_o    = pick.op;
  assign form_o  = pick_form;
  assign rc_o    = pick.rc;
  assign vd_o    = pick.rd;
  assign va_o    = pick.ra;
  assign vb_o    = pick.rb;

  always_comb begin
    // R1: the two sub-decoders never claim the same word
    a_r1_single_form: assert ($onehot0({std_res.hit, wide_res.hit}));
    if (valid_o && form_o == FORM_STD) begin
      a_r2_std_rc_pos: assert (rc_o == insn_i[10]);
    end
    if (valid_o && form_o == FORM_WIDE) begin
      a_r5_wide_rc_pos: assert (rc_o == insn_i[4]);
    end
    if (insn_i[31:26] == PRI_WIDE && insn_i[4] && insn_i[6]) begin
      a_r6_merge_rejected: assert (!valid_o);
    end
    if (!valid_o) begin
      a_r7_quiet_invalid: assert (!rc_o && op_o == 4'd0 && !form_o &&
                                  vd_o == '0 && va_o == '0 && vb_o == '0);
    end
  end

endmodule

// File: tb/vcmp_decode_tb.sv
module vcmp_decode_tb;

  logic        clk;
  logic [31:0] insn;
  logic        valid;
  logic [3:0]  op;
  logic        form;
  logic        rc;
  logic [6:0]  vd, va, vb;
  int          checks;
  int          errors;
  bit          done;

  vcmp_decode u_dut (
    .insn_i  (insn),
    .valid_o (valid),
    .op_o    (op),
    .form_o  (form),
    .rc_o    (rc),
    .vd_o    (vd),
    .va_o    (va),
    .vb_o    (vb)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] fill_pat(input int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'hA5A5_A5A5;
      default: return 32'h5A3C_96E1;
    endcase
  endfunction

  // R1 table: extended opcode -> operation code
  function automatic logic [3:0] std_code(input logic [9:0] x);
    logic [9:0] xs [13] = '{10'd6, 10'd70, 10'd134, 10'd198, 10'd454, 10'd710,
                            10'd966, 10'd518, 10'd582, 10'd646, 10'd774, 10'd838,
                            10'd902};
    logic [3:0] cs [13] = '{4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8,
                            4'd9, 4'd10, 4'd11, 4'd12, 4'd13};
    for (int i = 0; i < 13; i++) if (xs[i] == x) return cs[i];
    return 4'd0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s insn=%h got=%h exp=%h", tag, insn, got, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w);
    @(negedge clk);
    insn = w;
    #2;
  endtask

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    insn   = '0;

    // R7: all-zero word gives a quiet result
    apply(32'h0);
    chk("R7", {valid, op, form, rc, vd, va, vb}, 32'h0);

    // Wide space: every value of insn[9:4] against several fills
    for (int f = 0; f < 4; f++) begin
      for (int k = 0; k < 64; k++) begin
        logic [31:0] fw;
        logic [2:0]  s;
        logic        b6, b4, ev;
        logic [3:0]  ec;
        string       tg;
        fw = fill_pat(f);
        apply({6'd6, fw[25:10], k[5:0], fw[3:0]});
        s  = k[5:3];
        b6 = k[2];
        b4 = k[0];
        ec = 4'd0;
        if (!b4) begin
          tg = "R4";
          case (s)
            3'd0: ec = 4'd4;
            3'd1: ec = 4'd5;
            3'd2: ec = 4'd6;
            3'd4: ec = 4'd3;
            default: ec = 4'd0;
          endcase
        end else if (!b6) begin
          tg = "R5";
          if (s <= 3'd3) ec = 4'd4 + {1'b0, s};
          else if (s == 3'd4) ec = 4'd3;
        end else begin
          tg = "R6";
        end
        ev = (ec != 4'd0);
        if (!ev && tg != "R6") tg = "R7";
        chk(tg, {28'h0, ev, ev, (ev & b4), 1'b0} | {24'h0, ec, 4'h0},
            {28'h0, valid, form, rc, 1'b0} | {24'h0, op, 4'h0});
        if (ev)
          chk("R8", {11'h0, vd, va, vb},
              {11'h0, insn[3:2], insn[25:21], insn[5], insn[10], insn[20:16],
               insn[1:0], insn[15:11]});
        else
          chk("R7", {11'h0, vd, va, vb}, 32'h0);
      end
    end

    // Standard space: every extended opcode with both record values
    for (int f = 0; f < 2; f++) begin
      for (int x = 0; x < 1024; x++) begin
        for (int r = 0; r < 2; r++) begin
          logic [31:0] fw;
          logic [3:0]  ec;
          logic        ev;
          fw = fill_pat(f + 2);
          apply({6'd4, fw[25:11], r[0], x[9:0]});
          ec = std_code(x[9:0]);
          ev = (ec != 4'd0);
          if (ev) begin
            chk("R1", {26'h0, valid, form, op}, {26'h0, 1'b1, 1'b0, ec});
            chk("R2", {31'h0, rc}, {31'h0, r[0]});
            chk("R3", {11'h0, vd, va, vb},
                {11'h0, 2'b00, fw[25:21], 2'b00, fw[20:16], 2'b00, fw[15:11]});
          end else begin
            chk("R7", {valid, op, form, rc, vd, va, vb}, 32'h0);
          end
        end
      end
    end

    // R2: the least significant bit is never the record flag (odd opcode invalid)
    apply({6'd4, 15'h0, 1'b0, 10'd7});
    chk("R2", {31'h0, valid}, 32'h0);

    // R7: other primary opcodes with compare-like low bits
    for (int p = 0; p < 64; p++) begin
      if (p != 4 && p != 6) begin
        apply({p[5:0], 15'h1234, 1'b1, 10'd6});
        chk("R7", {valid, op, form, rc, vd, va, vb}, 32'h0);
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule